// File: doc/BRIEF.md
# Hyper Page DRAM Access Controller

This block sits between a simple host request port and an asynchronous DRAM with extended data out. The DRAM shares its address pins between row and column. Each host request carries a row, a column, a write flag and write data. The controller accepts the request and opens the row with a falling row strobe. It then presents the column and issues one column strobe per access. For a read, it returns the data word with a one-cycle valid pulse.

When the next request targets the same row, the row stays open and the next column follows directly, which forms a page burst. The row closes in three cases: the row changes, a refresh is pending, or the row strobe is close to its longest allowed low time. Every analogue timing limit is a parameter in picoseconds and is rounded up to whole clock cycles.

Writes always use the early form: the write strobe falls before the column strobe, so the memory never drives its data pins. The controller turns on its own data drivers only after the output enable has been high long enough for the memory output to switch off. Between accesses it hands the idle bus to an external refresh sequencer.

Top module: `hpm_dram_ctrl`

## Requirements
- R1: After reset, ras_n, cas_n, we_n and oe_n are 1, dq_oe and rd_valid are 0, and req_ready is 1 while ref_pending is 0.
- R2: The accepted request's row is on dram_addr when ras_n falls, and its column is on dram_addr when cas_n falls, in the order the requests were accepted; cas_n is never low while ras_n is high.
- R3: Read data is captured only when at least T_RAC_PS has passed since ras_n fell, T_CAC_PS since cas_n fell and T_AA_PS since the column address appeared. Capture happens on the same edge where cas_n rises, relying on the output staying valid after the column strobe. Reads return in order, each with a one-cycle rd_valid pulse.
- R4: A write lowers we_n at least one cycle before cas_n falls, with oe_n high, and dq_out holds the write data while dq_oe is 1 at the falling edge of cas_n.
- R5: dq_oe is 1 only while oe_n is 1 and we_n is 0, and only after oe_n has been high for at least T_OEZ_PS, so the controller and the memory never drive the data pins together.
- R6: ras_n stays low for at least T_RASMIN_PS, stays high for at least T_RP_PS before it falls again, and successive falls are at least T_RC_PS apart.
- R7: ras_n is never low for more than T_RASMAX_PS. A page burst is cut short when one more column could pass that limit.
- R8: A request to the row that is already open, arriving at the end of the column precharge, is served without a new ras_n fall.
- R9: A request to a different row closes the open row and opens the new one with a new ras_n fall.
- R10: While ref_pending is 1, no request is accepted and the open row is closed. ref_grant is 1 only in the idle state, with ras_n and cas_n high and dq_oe 0. If a same-row request and ref_pending both appear in the cycle the page decision is made, the refresh wins.
- R11: Between two columns of one page, cas_n stays high for at least T_CP_PS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted at the next clock edge |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| ref_pending | input | 1 | Refresh sequencer wants the bus |
| ref_grant | output | 1 | Bus idle and handed to refresh |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Memory output enable, active low |
| dq_out | output | DW | Write data toward the pins |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DW | Data from the pins |

## Verification
Two decisions can fall in the same cycle: a refresh request and a page hit, both arriving at the last cycle of the column precharge. The bench starts same-row bursts and raises ref_pending at eight different cycle offsets, so one of those offsets lands on that decision cycle. Every clock, a timestamp model of the memory checks the grant, the acceptance and the strobe states. After each offset, the bench also checks that the grant arrives within a bounded delay and that the interrupted burst's reads still return correct data. A second overlap is the page hit that meets the row-strobe ceiling. A long same-row burst provokes it, and the model judges it by the measured low time of every row.

// File: rtl/hpm_dram_ctrl.sv
module hpm_dram_ctrl #(
  parameter int ROW_W       = 13,
  parameter int COL_W       = 11,
  parameter int DW          = 16,
  parameter int CLK_PS      = 8000,
  parameter int T_RAC_PS    = 50000,
  parameter int T_CAC_PS    = 18000,
  parameter int T_AA_PS     = 30000,
  parameter int T_RC_PS     = 84000,
  parameter int T_RASMIN_PS = 50000,
  parameter int T_RASMAX_PS = 10000000,
  parameter int T_RP_PS     = 30000,
  parameter int T_CAS_PS    = 8000,
  parameter int T_CP_PS     = 10000,
  parameter int T_OEZ_PS    = 18000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [DW-1:0]        req_wdata,
  output logic                 req_ready,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid,
  input  logic                 ref_pending,
  output logic                 ref_grant,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic                 oe_n,
  output logic [DW-1:0]        dq_out,
  output logic                 dq_oe,
  input  logic [DW-1:0]        dq_in
);
  localparam int AW        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RAC_C     = (T_RAC_PS + CLK_PS - 1) / CLK_PS;
  localparam int CAC_C     = (T_CAC_PS + CLK_PS - 1) / CLK_PS;
  localparam int AA_C      = (T_AA_PS + CLK_PS - 1) / CLK_PS;
  localparam int RC_C      = (T_RC_PS + CLK_PS - 1) / CLK_PS;
  localparam int RASMIN_C  = (T_RASMIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int RASMAX_C  = T_RASMAX_PS / CLK_PS;
  localparam int RP_C      = (T_RP_PS + CLK_PS - 1) / CLK_PS;
  localparam int CAS_C     = (T_CAS_PS + CLK_PS - 1) / CLK_PS;
  localparam int CP_C      = (T_CP_PS + CLK_PS - 1) / CLK_PS;
  localparam int OEZ_C     = (T_OEZ_PS + CLK_PS - 1) / CLK_PS;
  localparam int COLMAX_C  = OEZ_C + 2 + RAC_C + AA_C + CAC_C + CAS_C + CP_C;
  localparam int M1        = (RAC_C > AA_C) ? RAC_C : AA_C;
  localparam int M2        = (CAC_C > CP_C) ? CAC_C : CP_C;
  localparam int M3        = (RP_C > OEZ_C) ? RP_C : OEZ_C;
  localparam int M4        = (M1 > M2) ? M1 : M2;
  localparam int SMAX      = (M3 > M4) ? ((M3 > CAS_C) ? M3 : CAS_C) : ((M4 > CAS_C) ? M4 : CAS_C);
  localparam int SW        = $clog2(SMAX + 2);
  localparam int RW        = $clog2(((RASMAX_C > RC_C) ? RASMAX_C : RC_C) + 2);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_COL, S_CAS, S_CP, S_HOLD, S_PRE} st_t;
  st_t st;

  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] p_col;
  logic             p_wr;
  logic [DW-1:0]    p_wd;
  logic [RW-1:0]    rc;
  logic [SW-1:0]    cc, ac, pc, oz;

  logic cp_done, page_ok, cas_done;

  assign cp_done  = int'(pc) + 1 >= CP_C;
  assign page_ok  = req_valid && !ref_pending && (req_row == open_row) &&
                    (int'(rc) + COLMAX_C + 2 < RASMAX_C);
  assign cas_done = (int'(cc) + 1 >= CAS_C) &&
                    (p_wr || ((int'(cc) + 1 >= CAC_C) && (int'(ac) + 1 >= AA_C) &&
                              (int'(rc) + 1 >= RAC_C)));
  assign req_ready = (st == S_IDLE && !ref_pending) || (st == S_CP && cp_done && page_ok);
  assign ref_grant = (st == S_IDLE) && ref_pending;
  assign dq_out    = p_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ras_n <= 1'b1; cas_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1; dq_oe <= 1'b0;
      dram_addr <= '0; open_row <= '0; p_col <= '0; p_wr <= 1'b0; p_wd <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
      rc <= '1; cc <= '1; ac <= '1; pc <= '1; oz <= '1;
    end else begin
      rd_valid <= 1'b0;
      if (rc != '1) rc <= rc + 1'b1;
      if (cc != '1) cc <= cc + 1'b1;
      if (ac != '1) ac <= ac + 1'b1;
      if (pc != '1) pc <= pc + 1'b1;
      if (!oe_n) oz <= '0;
      else if (oz != '1) oz <= oz + 1'b1;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          st <= S_ACT; ras_n <= 1'b0; rc <= '0;
          dram_addr <= AW'(req_row); open_row <= req_row;
          p_col <= req_col; p_wr <= req_write; p_wd <= req_wdata;
        end
        S_ACT: begin
          st <= S_COL; dram_addr <= AW'(p_col);
          we_n <= !p_wr; oe_n <= p_wr; ac <= '0;
        end
        S_COL: begin
          if (!p_wr || dq_oe) begin
            st <= S_CAS; cas_n <= 1'b0; cc <= '0;
          end else if (oe_n && int'(oz) + 1 >= OEZ_C) begin
            dq_oe <= 1'b1;
          end
        end
        S_CAS: if (cas_done) begin
          st <= S_CP; cas_n <= 1'b1; dq_oe <= 1'b0; pc <= '0;
          if (!p_wr) begin
            rd_data <= dq_in; rd_valid <= 1'b1;
          end
        end
        S_CP: if (cp_done) begin
          if (page_ok) begin
            st <= S_COL; dram_addr <= AW'(req_col);
            we_n <= !req_write; oe_n <= req_write; ac <= '0;
            p_col <= req_col; p_wr <= req_write; p_wd <= req_wdata;
          end else begin
            st <= S_HOLD; we_n <= 1'b1; oe_n <= 1'b1;
          end
        end
        S_HOLD: if (int'(rc) + 1 >= RASMIN_C) begin
          st <= S_PRE; ras_n <= 1'b1; pc <= '0;
        end
        S_PRE: if (int'(pc) + 1 >= RP_C && int'(rc) + 1 >= RC_C) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R2
  AST_CAPTURE_AT_CAS_RISE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $rose(cas_n) && we_n); // R3
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R3
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(cas_n) && !we_n) |-> !$past(we_n) && oe_n && dq_oe); // R4
  AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> oe_n && !we_n && int'(oz) >= OEZ_C); // R5
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> int'(rc) >= RASMIN_C); // R6
  AST_RAS_CEILING: assert property (@(posedge clk) disable iff (!rst_n) !ras_n |-> int'(rc) < RASMAX_C); // R7
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ref_grant |-> ras_n && cas_n && !dq_oe); // R10
endmodule

// File: tb/hpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module hpm_dram_ctrl_tb;
  localparam int ROW_W = 13, COL_W = 11, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_pending = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0, rd_data, dq_out, dq_in = '0;
  logic req_ready, rd_valid, ref_grant, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0] dram_addr;

  hpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .ref_pending(ref_pending), .ref_grant(ref_grant),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #4 clk = ~clk;

  int total = 0, bad = 0, nras = 0;
  bit done = 0;
  logic [DW-1:0] mem [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_q [$];
  int acc_q [$];

  function automatic logic [DW-1:0] seed(int k);
    return DW'(k * 29 + 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Behavioural memory: timestamps in ns, sampled 6 ns after each rising edge.
  longint r_f = -1000, r_r = -1000, c_r = -1000, o_r = -1000, a_t = -1000;
  longint rd_cf, rd_at, rd_rf;
  int row_l, rd_key;
  bit rd_act = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, p_dqoe = 0;
  logic [ROW_W-1:0] p_addr = '0;

  always @(negedge clk) begin
    longint t;
    int key;
    logic [DW-1:0] v;
    #2;
    t = $time - 6;
    if (rst_n) begin
      if (dram_addr != p_addr) a_t = t;
      if (p_ras && !ras_n) begin
        chk(t - r_r >= 30, "R6 precharge", t - r_r, 30);
        chk(t - r_f >= 84, "R6 cycle", t - r_f, 84);
        r_f = t; row_l = int'(dram_addr); nras++;
      end
      if (!p_ras && ras_n) begin
        chk(t - r_f >= 50, "R6 low", t - r_f, 50);
        chk(t - r_f <= 10000, "R7 low", t - r_f, 10000);
        r_r = t;
      end
      if (p_cas && !cas_n) begin
        chk(!ras_n, "R2 cas under ras", ras_n, 0);
        key = (row_l << COL_W) | int'(dram_addr[COL_W-1:0]);
        if (acc_q.size() == 0) chk(0, "R2 unexpected access", key, -1);
        else begin
          chk(key == acc_q[0], "R2 address", key, acc_q[0]);
          void'(acc_q.pop_front());
        end
        if (c_r > r_f) chk(t - c_r >= 10, "R11 cas high", t - c_r, 10);
        if (!we_n) begin
          chk(!p_we, "R4 we before cas", p_we, 0);
          chk(dq_oe && oe_n, "R4 driven with oe high", {dq_oe, oe_n}, 3);
          mem[key] = dq_out;
        end else begin
          rd_key = key; rd_cf = t; rd_at = a_t; rd_rf = r_f; rd_act = 1;
        end
      end
      if (!p_cas && cas_n) c_r = t;
      if (!p_oe && oe_n) o_r = t;
      if (oe_n || !we_n || (ras_n && cas_n)) rd_act = 0;
      if (dq_oe && !p_dqoe) chk(t - o_r >= 18 && oe_n, "R5 oe off before drive", t - o_r, 18);
      chk(!(dq_oe && rd_act), "R5 contention", rd_act, 0);
      if (ref_grant) chk(ras_n && cas_n, "R10 grant quiet", {ras_n, cas_n}, 3);
      if (ref_pending) chk(!req_ready, "R10 no accept", req_ready, 0);
      if (!ras_n) chk(t - r_f <= 10000, "R7 ceiling", t - r_f, 10000);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R3 spurious read", rd_data, -1);
        else begin
          chk(rd_data == exp_q[0], "R3 read data", rd_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
    v = mem.exists(rd_key) ? mem[rd_key] : seed(rd_key);
    if (rd_act && t + 8 >= rd_rf + 50 && t + 8 >= rd_cf + 18 && t + 8 >= rd_at + 30) dq_in = v;
    else dq_in = ~v;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe; p_addr = dram_addr;
  end

  task automatic req(input bit w, input int row, input int col, input logic [DW-1:0] d);
    int key;
    @(negedge clk);
    req_valid = 1; req_write = w; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    key = (row << COL_W) | col;
    if (w) shadow[key] = d;
    else exp_q.push_back(shadow.exists(key) ? shadow[key] : seed(key));
    acc_q.push_back(key);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary;
      $finish;
    end
  end

  initial begin
    int c0, lat;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid, "R1 outputs", {dq_oe, rd_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    req(1, 5, 3, 16'hA1A1);
    req(0, 5, 3, 16'h0);
    req(0, 5, 4, 16'h0);
    req(1, 5, 4, 16'h5A5A);
    req(0, 5, 4, 16'h0);
    idle(40);

    c0 = nras;
    for (int i = 0; i < 4; i++) req(0, 9, i, 16'h0);
    idle(40);
    chk(nras - c0 == 1, "R8 one row open", nras - c0, 1);

    c0 = nras;
    req(1, 2, 7, 16'h1234);
    req(0, 3, 7, 16'h0);
    req(0, 2, 7, 16'h0);
    idle(40);
    chk(nras - c0 == 3, "R9 row changes", nras - c0, 3);

    for (int i = 0; i < 30; i++)
      req(i % 3 == 0, (i % 7 < 4) ? 6 : 7 + i % 2, (i * 5) % 64, DW'(i * 16'h1111));
    idle(40);

    c0 = nras;
    for (int i = 0; i < 230; i++) req(0, 11, i % 2048, 16'h0);
    idle(40);
    chk(nras - c0 >= 2, "R7 burst split", nras - c0, 2);

    for (int off = 0; off < 8; off++) begin
      fork
        begin
          for (int i = 0; i < 8; i++) req(i == 2, 12, i + off * 8, DW'(off));
        end
        begin
          repeat (off + 4) @(negedge clk);
          ref_pending = 1;
          lat = 0;
          #3;
          while (!ref_grant && lat < 200) begin @(negedge clk); #3; lat++; end
          chk(lat <= 60, "R10 grant latency", lat, 60);
          idle(5);
          ref_pending = 0;
        end
      join
    end
    idle(60);
    chk(exp_q.size() == 0, "R3 reads returned", exp_q.size(), 0);
    chk(acc_q.size() == 0, "R2 accesses issued", acc_q.size(), 0);
    done = 1;
    summary;
    $finish;
  end
endmodule